// File: doc/BRIEF.md
# Receive Ring Data-Port Reader

This block is the host side of the read port for a receive packet memory. The memory holds received frames back to back in a ring. Each frame starts with a ready marker byte and a status byte, then a two-byte byte count (the count includes the four trailing CRC bytes), then the frame data, then the CRC. The host first writes an index to select what the data port returns. It then issues reads on the data port. One index peeks at the bytes under the read pointer and leaves the pointer where it is. Another index returns the same bytes and moves the pointer past them.

The host uses the peek to test whether a frame is waiting: a marker of 0 means nothing is pending, 1 means a frame is ready, and any other value means the ring is corrupt. After that it drains the header and the payload with advancing reads. In the status byte, bit 6 flags a multicast frame, and the mask 0xBF selects the error bits. A count above 1536 also means the ring is corrupt. The host interprets all of these values; this block only moves bytes.

The port transfers one byte per read in 8-bit bus mode and two bytes per read, low byte first, in the wider modes. A bus-mode strap selects the mode, and the host can read the mode back. Data-port reads use a valid/ready request stream and a valid/ready response stream with a single holding slot. While a response waits unconsumed, new requests are refused. The memory is read asynchronously at two byte addresses: the pointer and its ring successor.

Top module: `rxbuf_rdport`

## Requirements
- R1: After reset the read pointer is RING_BASE (0 by default), the selected index is 0x00, `rsp_valid` is low and `req_ready` is high.
- R2: With index 0xF0 selected, a read returns the bytes at the pointer and leaves the pointer unchanged. In 8-bit mode (`bus_mode` = 2'b10) the byte is in bits [7:0] and bits [15:8] are zero. In any other mode bits [7:0] hold the byte at the pointer and bits [15:8] hold the byte at its ring successor.
- R3: With index 0xF2 selected, a read returns the same layout as R2 and then advances the pointer: by 1 in 8-bit mode, by 2 otherwise.
- R4: The pointer and the successor address wrap from RING_BASE+RING_BYTES-1 to RING_BASE, and the pointer never leaves that range.
- R5: Index 0xF4 returns pointer bits [7:0] in bits [7:0] and index 0xF5 returns pointer bits [15:8] in bits [7:0]. Neither read moves the pointer.
- R6: Index 0xFE returns the bus mode code in bits [7:6] and zero in every other bit. The codes are 00 for 16-bit, 01 for 32-bit and 10 for 8-bit. 32-bit mode moves data as 16-bit mode does.
- R7: Any other index returns 0x0000 and leaves the pointer unchanged.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. Its response appears on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `req_ready` stays low. `req_ready` is high whenever the slot is empty or is being emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index write strobe |
| idx_data | input | 8 | Index value to select |
| req_valid | input | 1 | Data-port read request |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response slot holds data |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Response data |
| bus_mode | input | 2 | Bus mode strap (00 16-bit, 01 32-bit, 10 8-bit) |
| mem_addr_lo | output | 16 | Byte address at the pointer |
| mem_addr_hi | output | 16 | Ring successor of the pointer |
| mem_byte_lo | input | 8 | Memory byte at mem_addr_lo |
| mem_byte_hi | input | 8 | Memory byte at mem_addr_hi |

## Verification
A response is due one cycle after the edge that accepts its request. A pointer move becomes visible to the next accepted request. The bench drives each request at a falling edge and samples the response at the next falling edge, which is one acceptance edge later. It checks every returned value against a model pointer kept in the bench and a byte pattern computed arithmetically. Stall checks hold `rsp_ready` low over several falling edges. They then confirm that the pointer moved exactly once, using the pointer readback indices.

// File: rtl/rxbuf_rd_pkg.sv
package rxbuf_rd_pkg;
  localparam int PTR_W  = 16;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    BUS_W16  = 2'b00,
    BUS_W32  = 2'b01,
    BUS_W8   = 2'b10,
    BUS_RSVD = 2'b11
  } bus_mode_e;

  localparam logic [7:0] IDX_PEEK   = 8'hF0;
  localparam logic [7:0] IDX_POP    = 8'hF2;
  localparam logic [7:0] IDX_PTR_LO = 8'hF4;
  localparam logic [7:0] IDX_PTR_HI = 8'hF5;
  localparam logic [7:0] IDX_STAT   = 8'hFE;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              adv;
    logic              step2;
  } rd_result_t;
endpackage

// File: rtl/rxbuf_rd_ptr.sv
module rxbuf_rd_ptr
  import rxbuf_rd_pkg::*;
#(
  parameter int RING_BASE  = 0,
  parameter int RING_BYTES = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             step2,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] ptr_p1
);
  localparam logic [PTR_W:0]   END_V  = (PTR_W+1)'(RING_BASE + RING_BYTES);
  localparam logic [PTR_W:0]   SIZE_V = (PTR_W+1)'(RING_BYTES);
  localparam logic [PTR_W-1:0] BASE_V = PTR_W'(RING_BASE);

  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] p,
                                                 input logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + {{(PTR_W-1){1'b0}}, k};
    if (s >= END_V) s = s - SIZE_V;
    return s[PTR_W-1:0];
  endfunction

  logic [PTR_W-1:0] ptr_d;

  assign ptr_p1 = ring_add(ptr_q, 2'd1);

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = ring_add(ptr_q, step2 ? 2'd2 : 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= BASE_V;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/rxbuf_rd_fmt.sv
module rxbuf_rd_fmt
  import rxbuf_rd_pkg::*;
(
  input  logic [7:0]       idx,
  input  logic [1:0]       mode,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0]       b_lo,
  input  logic [7:0]       b_hi,
  output rd_result_t       res
);
  logic              wide;
  logic [DATA_W-1:0] pair;

  assign wide = (mode != BUS_W8);
  assign pair = wide ? {b_hi, b_lo} : {8'h00, b_lo};

  always_comb begin
    res = '0;
    case (idx)
      IDX_PEEK:   res.data = pair;
      IDX_POP: begin
        res.data  = pair;
        res.adv   = 1'b1;
        res.step2 = wide;
      end
      IDX_PTR_LO: res.data = {8'h00, ptr[7:0]};
      IDX_PTR_HI: res.data = {8'h00, ptr[15:8]};
      IDX_STAT:   res.data = {8'h00, mode, 6'b000000};
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/rxbuf_rd_out.sv
module rxbuf_rd_out
  import rxbuf_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= din;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxbuf_rdport.sv
module rxbuf_rdport
  import rxbuf_rd_pkg::*;
#(
  parameter int RING_BASE  = 0,
  parameter int RING_BYTES = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic [7:0]  idx_data,
  input  logic        req_valid,
  output logic        req_ready,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data,
  input  logic [1:0]  bus_mode,
  output logic [15:0] mem_addr_lo,
  output logic [15:0] mem_addr_hi,
  input  logic [7:0]  mem_byte_lo,
  input  logic [7:0]  mem_byte_hi
);
  logic [7:0]       idx_q;
  logic             accept;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_p1;
  rd_result_t       res;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= 8'h00;
    else if (idx_wr) idx_q <= idx_data;
  end

  assign accept      = req_valid && req_ready;
  assign mem_addr_lo = ptr_q;
  assign mem_addr_hi = ptr_p1;

  rxbuf_rd_ptr #(.RING_BASE(RING_BASE), .RING_BYTES(RING_BYTES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (accept && res.adv),
    .step2  (res.step2),
    .ptr_q  (ptr_q),
    .ptr_p1 (ptr_p1)
  );

  rxbuf_rd_fmt u_fmt (
    .idx  (idx_q),
    .mode (bus_mode),
    .ptr  (ptr_q),
    .b_lo (mem_byte_lo),
    .b_hi (mem_byte_hi),
    .res  (res)
  );

  rxbuf_rd_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .din       (res.data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .can_take  (req_ready)
  );
endmodule

// File: rtl/rxbuf_rdport_chk.sv
module rxbuf_rdport_chk #(
  parameter int RING_BASE  = 0,
  parameter int RING_BYTES = 16384
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic [15:0] ptr
);
  localparam logic [16:0] LO_V = 17'(RING_BASE);
  localparam logic [16:0] SZ_V = 17'(RING_BYTES);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R8
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R3
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(ptr));

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, ptr} - LO_V) < SZ_V));
endmodule

bind rxbuf_rdport rxbuf_rdport_chk #(.RING_BASE(RING_BASE), .RING_BYTES(RING_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ptr       (ptr_q)
);

// File: tb/rxbuf_rdport_test.sv
`timescale 1ns/1ps
module rxbuf_rdport_test;
  localparam int RB = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [7:0]  idx_data = 8'h00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [1:0]  bus_mode = 2'b10;
  logic [15:0] mem_addr_lo, mem_addr_hi;
  logic [7:0]  mem_byte_lo, mem_byte_hi;

  int checks = 0;
  int fails  = 0;
  int mp     = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] val(input int a);
    return 8'(a * 37 + 5);
  endfunction

  function automatic int nx(input int a);
    return (a + 1) % RB;
  endfunction

  assign mem_byte_lo = (int'(mem_addr_lo) < RB) ? val(int'(mem_addr_lo)) : 8'hEE;
  assign mem_byte_hi = (int'(mem_addr_hi) < RB) ? val(int'(mem_addr_hi)) : 8'hEE;

  rxbuf_rdport #(.RING_BASE(0), .RING_BYTES(RB)) uut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(idx_data),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .bus_mode(bus_mode),
    .mem_addr_lo(mem_addr_lo), .mem_addr_hi(mem_addr_hi),
    .mem_byte_lo(mem_byte_lo), .mem_byte_hi(mem_byte_hi)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; idx_data = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic do_read(output logic [15:0] d);
    @(negedge clk); req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R8 latency", 16'(rsp_valid), 16'd1);
    d = rsp_data;
  endtask

  task automatic check_ptr(input string req);
    logic [15:0] lo, hi;
    set_idx(8'hF4); do_read(lo);
    set_idx(8'hF5); do_read(hi);
    check(req, {hi[7:0], lo[7:0]}, 16'(mp));
    check("R5 upper zero", {lo[15:8], hi[15:8]}, 16'h0000);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 16'(rsp_valid), 16'd0);
    check("R1 req_ready", 16'(req_ready), 16'd1);
    do_read(d);
    check("R1 index 0 reads zero", d, 16'h0000);
    check_ptr("R1 pointer at reset");

    // R2: peek in 8-bit mode does not advance
    bus_mode = 2'b10;
    set_idx(8'hF0);
    for (int i = 0; i < 3; i++) begin
      do_read(d);
      check("R2 peek 8-bit", d, {8'h00, val(mp)});
    end
    check_ptr("R2 peek keeps pointer");

    // R3 R4: advancing sweep in 8-bit mode past the ring end twice
    set_idx(8'hF2);
    for (int i = 0; i < 2 * RB + 3; i++) begin
      do_read(d);
      check("R3 R4 pop 8-bit", d, {8'h00, val(mp)});
      mp = nx(mp);
    end
    check_ptr("R4 pointer after 8-bit wrap");

    // R3 R4: 16-bit sweep from an odd pointer, second byte wraps too
    bus_mode = 2'b00;
    set_idx(8'hF2);
    for (int i = 0; i < RB + 2; i++) begin
      do_read(d);
      check("R3 R4 pop 16-bit", d, {val(nx(mp)), val(mp)});
      mp = nx(nx(mp));
    end
    check_ptr("R3 pointer after 16-bit sweep");

    // R2: peek in 16-bit mode
    set_idx(8'hF0);
    do_read(d);
    check("R2 peek 16-bit", d, {val(nx(mp)), val(mp)});
    do_read(d);
    check("R2 peek 16-bit repeat", d, {val(nx(mp)), val(mp)});

    // R6: status for every mode; 32-bit moves like 16-bit
    for (int m = 0; m < 3; m++) begin
      bus_mode = 2'(m);
      set_idx(8'hFE);
      do_read(d);
      check("R6 status mode", d, 16'(m << 6));
    end
    bus_mode = 2'b01;
    set_idx(8'hF2);
    for (int i = 0; i < 5; i++) begin
      do_read(d);
      check("R6 pop 32-bit", d, {val(nx(mp)), val(mp)});
      mp = nx(nx(mp));
    end
    check_ptr("R6 pointer after 32-bit reads");

    // R7: unknown indices
    foreach (d[i]) begin end
    set_idx(8'h33); do_read(d); check("R7 unknown index", d, 16'h0000);
    set_idx(8'hF1); do_read(d); check("R7 unknown index F1", d, 16'h0000);
    check_ptr("R7 pointer unchanged");

    // R8: back-pressure holds data and blocks requests
    bus_mode = 2'b10;
    set_idx(8'hF2);
    @(negedge clk); req_valid = 1'b1; rsp_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 held valid", 16'(rsp_valid), 16'd1);
      check("R8 held data", rsp_data, {8'h00, val(mp)});
      check("R8 ready low", 16'(req_ready), 16'd0);
    end
    req_valid = 1'b0;
    @(negedge clk); rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 slot drained", 16'(rsp_valid), 16'd0);
    check("R8 ready again", 16'(req_ready), 16'd1);
    mp = nx(mp);
    check_ptr("R8 single advance under stall");

    summary();
  end
endmodule